// File: doc/BRIEF.md
# Generalized Bit-Reverse Execution Unit

This unit executes the generalized reverse permutation for a 64-bit processor. It receives one 32-bit instruction word and two 64-bit source operands with a strobe. It recognises four instruction variants:

- the amount comes from a register operand or from an immediate;
- the permutation works on a 64-bit doubleword or on a 32-bit word.

It moves every source bit at index i to index i XOR amount. The result, the destination register index, an optional 4-bit condition field with its write enable, and a valid flag all appear one clock after the strobe.

The permutation network has one stage per amount bit. Stage k exchanges neighbouring blocks of 2^k bits when bit k of the amount is set. Word mode clears the upper half of the input and holds the top stage off, so nothing can reach the upper 32 result bits. Any instruction word that is not one of the four variants gives no valid result.

Top module: `grev_unit`

## Requirements
- R1: For a doubleword variant, result bit (i XOR amt) equals source A bit i for every i in 0..63, where amt is the amount taken modulo 64.
- R2: For a word variant, the amount is taken modulo 32 and only source A bits 31..0 are permuted. Result bit (i XOR amt) equals source A bit i for i in 0..31, and result bits 63..32 are zero.
- R3: Instruction bits 31..26 must equal 5. Bits 25..21 give the destination index, which is presented on `res_rt`. Bit 0 is the record flag.
- R4: In the register forms, bits 10..1 hold the extended code: 0x096 for doubleword and 0x0B6 for word. The amount comes from source B bits 5..0 (doubleword) or 4..0 (word), and the upper bits of B are ignored.
- R5: The doubleword immediate form has the amount in bits 15..10 and the code 0x0D6 in bits 9..1. The word immediate form has the amount in bits 15..11 and the code 0x0F6 in bits 10..1.
- R6: With the record flag at 1, `res_cr_we` is 1 and `res_cr` is {lt, gt, eq, 0}, taken from the 64-bit result read as signed. Exactly one of bits 3..1 is set.
- R7: With the record flag at 0, `res_cr_we` is 0 and `res_cr` is zero.
- R8: A strobed instruction word that matches none of the four variants gives `res_valid`=0, a zero result and `res_cr_we`=0.
- R9: Outputs register one cycle after `in_valid`. Without a strobe, `res_valid` is 0 and the result is zero. A synchronous active-high `rst` clears all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 32 | Instruction word |
| src_a | input | 64 | Operand that is permuted |
| src_b | input | 64 | Register amount operand |
| res_valid | output | 1 | Registered result is valid |
| res_data | output | 64 | Permuted result |
| res_rt | output | 5 | Destination register index |
| res_cr | output | 4 | Condition field {lt, gt, eq, 0} |
| res_cr_we | output | 1 | Condition field update enable |

## Verification
The properties assume that `in_valid`, `insn` and the operands are stable around the sampling edge. They also assume that a strobe and reset may be asserted in the same cycle, with reset taking priority. The bench drives every input on the falling edge and removes the strobe after one cycle. Reset is raised only while the strobe is low or on a falling edge, so each property sees one well-formed request per cycle. The random operands and amounts cover all four variants. The fields an instruction ignores, such as the B register index in immediate forms and the upper bits of B, are also randomised, so that leakage from them shows up in the result.

// File: rtl/grev_unit.sv
module grev_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic [4:0]      res_rt,
  output logic [3:0]      res_cr,
  output logic            res_cr_we
);
  localparam int LG   = $clog2(XLEN);
  localparam int HALF = XLEN / 2;

  logic po_ok, is_dr, is_wr, is_wi, is_di, hit, word, take;
  logic [LG-1:0] amt;
  logic [XLEN-1:0] st [0:LG];
  logic [XLEN-1:0] perm;
  logic [3:0] cr;
  logic unused_bits;

  assign po_ok = insn[31:26] == 6'd5;
  assign is_dr = po_ok && insn[10:1] == 10'h096;
  assign is_wr = po_ok && insn[10:1] == 10'h0B6;
  assign is_wi = po_ok && insn[10:1] == 10'h0F6;
  assign is_di = po_ok && insn[9:1]  == 9'h0D6;
  assign hit   = is_dr | is_wr | is_wi | is_di;
  assign word  = is_wr | is_wi;
  assign take  = in_valid && hit;

  always_comb begin
    if (is_di)      amt = insn[10 +: LG];
    else if (is_wi) amt = {1'b0, insn[11 +: LG-1]};
    else if (is_wr) amt = {1'b0, src_b[LG-2:0]};
    else            amt = src_b[LG-1:0];
  end

  assign st[0] = word ? {{HALF{1'b0}}, src_a[HALF-1:0]} : src_a;

  for (genvar k = 0; k < LG; k++) begin : g_stage
    logic en;
    assign en = amt[k] && !(word && k == LG-1);
    for (genvar j = 0; j < XLEN; j++) begin : g_bit
      assign st[k+1][j] = en ? st[k][j ^ (1 << k)] : st[k][j];
    end
  end

  assign perm = st[LG];
  assign cr = {perm[XLEN-1], !perm[XLEN-1] && (perm != '0), perm == '0, 1'b0};
  assign unused_bits = ^{insn[20:16], src_b[XLEN-1:LG]};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_rt    <= '0;
      res_cr    <= '0;
      res_cr_we <= 1'b0;
    end else begin
      res_valid <= take;
      res_data  <= take ? perm : '0;
      res_rt    <= take ? insn[25:21] : 5'd0;
      res_cr_we <= take && insn[0];
      res_cr    <= (take && insn[0]) ? cr : 4'd0;
    end
  end
endmodule

// File: rtl/grev_unit_checks.sv
module grev_unit_checks (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] insn,
  input logic [63:0] src_a,
  input logic        res_valid,
  input logic [63:0] res_data,
  input logic [3:0]  res_cr,
  input logic        res_cr_we
);
  logic dw_req, w_req;
  assign dw_req = in_valid && insn[31:26] == 6'd5 &&
                  (insn[10:1] == 10'h096 || insn[9:1] == 9'h0D6);
  assign w_req  = in_valid && insn[31:26] == 6'd5 &&
                  (insn[10:1] == 10'h0B6 || insn[10:1] == 10'h0F6);

  p_ones_kept_r1: assert property (@(posedge clk) disable iff (rst)
    dw_req |=> res_valid && $countones(res_data) == $countones($past(src_a)));

  p_word_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    w_req |=> res_valid && res_data[63:32] == 32'd0 &&
              $countones(res_data) == $countones($past(src_a[31:0])));

  p_bad_primary_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[31:26] != 6'd5) |=> !res_valid);

  p_cr_shape_r6: assert property (@(posedge clk) disable iff (rst)
    res_cr_we |-> res_valid && $countones(res_cr[3:1]) == 1 && !res_cr[0]);

  p_no_record_r7: assert property (@(posedge clk) disable iff (rst)
    ((dw_req || w_req) && !insn[0]) |=> !res_cr_we && res_cr == 4'd0);

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> res_data == 64'd0 && !res_cr_we);

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid));
endmodule

bind grev_unit grev_unit_checks u_checks (
  .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .src_a(src_a),
  .res_valid(res_valid), .res_data(res_data), .res_cr(res_cr),
  .res_cr_we(res_cr_we)
);

// File: tb/grev_unit_bench.sv
`timescale 1ns/1ps
module grev_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        res_valid, res_cr_we;
  logic [63:0] res_data;
  logic [4:0]  res_rt;
  logic [3:0]  res_cr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  grev_unit u_grev_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src_a(src_a), .src_b(src_b), .res_valid(res_valid),
    .res_data(res_data), .res_rt(res_rt), .res_cr(res_cr),
    .res_cr_we(res_cr_we)
  );

  function automatic logic [63:0] ref_grev(input logic [63:0] a, input int amt, input bit w);
    logic [63:0] r = '0;
    int bits = w ? 32 : 64;
    for (int i = 0; i < bits; i++)
      if (a[i]) r[i ^ amt] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] build(input bit w, input bit imm, input bit rc,
                                        input logic [4:0] rt, input logic [4:0] ra,
                                        input logic [5:0] fld);
    if (!w && imm) return {6'd5, rt, ra, fld, 9'h0D6, rc};
    if (w && imm)  return {6'd5, rt, ra, fld[4:0], 10'h0F6, rc};
    if (w)         return {6'd5, rt, ra, fld[4:0], 10'h0B6, rc};
    return {6'd5, rt, ra, fld[4:0], 10'h096, rc};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input bit w, input bit imm, input bit rc, input logic [4:0] rt,
                     input logic [63:0] a, input logic [63:0] b,
                     input logic [5:0] immv, input string tag);
    int amt;
    logic [63:0] exp;
    logic [3:0] ecr;
    logic [5:0] fld;
    fld = imm ? immv : {1'b0, 5'($urandom)};
    if (imm) amt = w ? int'(immv[4:0]) : int'(immv);
    else     amt = w ? int'(b[4:0]) : int'(b[5:0]);
    exp = ref_grev(a, amt, w);
    if ($signed(exp) < 0)      ecr = 4'b1000;
    else if ($signed(exp) > 0) ecr = 4'b0100;
    else                       ecr = 4'b0010;
    if (!rc) ecr = 4'd0;
    @(negedge clk);
    in_valid = 1'b1;
    insn = build(w, imm, rc, rt, 5'($urandom), fld);
    src_a = a;
    src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(res_valid == 1'b1, "R9", "valid", 64'(res_valid), 64'd1);
    check(res_data == exp, tag, "result", res_data, exp);
    check(res_rt == rt, "R3", "rt", 64'(res_rt), 64'(rt));
    check(res_cr_we == rc, rc ? "R6" : "R7", "cr_we", 64'(res_cr_we), 64'(rc));
    check(res_cr == ecr, rc ? "R6" : "R7", "cr", 64'(res_cr), 64'(ecr));
  endtask

  task automatic run_bad(input logic [31:0] word, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    insn = word;
    src_a = {$urandom, $urandom};
    src_b = {$urandom, $urandom};
    @(negedge clk);
    in_valid = 1'b0;
    check(res_valid == 1'b0, tag, "valid on bad word", 64'(res_valid), 64'd0);
    check(res_data == 64'd0, tag, "result on bad word", res_data, 64'd0);
    check(res_cr_we == 1'b0, tag, "cr_we on bad word", 64'(res_cr_we), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0 && res_data == 64'd0 && res_cr_we == 1'b0, "R9",
          "reset state", res_data, 64'd0);
    rst = 1'b0;

    // R1 directed: identity and full reversal
    run(0, 0, 1, 5'd3, 64'h0123_4567_89AB_CDEF, 64'd0, 6'd0, "R1");
    run(0, 1, 1, 5'd7, 64'h8000_0000_0000_0001, 64'd0, 6'd63, "R1");
    run(0, 1, 0, 5'd9, 64'h0000_0000_0000_00F0, 64'd0, 6'd63, "R5");
    // R4: upper bits of B ignored
    run(0, 0, 1, 5'd1, 64'hDEAD_BEEF_0000_1234, 64'hFFFF_FFFF_FFFF_FFC5, 6'd0, "R4");
    run(1, 0, 1, 5'd2, 64'h0000_0000_1234_5678, 64'hFFFF_FFFF_FFFF_FFE7, 6'd0, "R4");
    // R2: upper half of A dropped in word mode
    run(1, 1, 1, 5'd4, 64'hFFFF_FFFF_0000_0000, 64'd0, 6'd6, "R2");
    run(1, 1, 1, 5'd5, 64'hFFFF_FFFF_8000_0000, 64'd0, 6'd31, "R2");
    run(1, 0, 0, 5'd6, 64'hAAAA_AAAA_5555_5555, 64'd33, 6'd0, "R2");
    // R6: each condition
    run(0, 0, 1, 5'd8, 64'd0, 64'd17, 6'd0, "R6");
    run(0, 1, 1, 5'd8, 64'd1, 64'd0, 6'd63, "R6");
    run(0, 1, 1, 5'd8, 64'd1, 64'd0, 6'd1, "R6");

    // R8 / R3: malformed words
    run_bad({6'd4, 5'd3, 5'd4, 5'd5, 10'h096, 1'b1}, "R3");
    run_bad({6'd5, 5'd3, 5'd4, 5'd5, 10'h097, 1'b1}, "R8");
    run_bad({6'd5, 5'd3, 5'd4, 5'd5, 10'h2B6, 1'b0}, "R8");
    run_bad(32'h0000_0000, "R8");

    // R9: no strobe gives no valid
    @(negedge clk);
    insn = build(0, 0, 1, 5'd3, 5'd4, 6'd5);
    @(negedge clk);
    check(res_valid == 1'b0 && res_data == 64'd0, "R9", "no strobe",
          res_data, 64'd0);

    // R9: reset clears a pending result
    run(0, 0, 1, 5'd11, 64'hFFFF_0000_FFFF_0000, 64'd4, 6'd0, "R1");
    @(negedge clk);
    in_valid = 1'b1;
    insn = build(0, 0, 1, 5'd12, 5'd4, 6'd5);
    src_a = 64'hFFFF;
    src_b = 64'd3;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(res_valid == 1'b0 && res_cr_we == 1'b0 && res_rt == 5'd0, "R9",
          "mid reset", 64'(res_valid), 64'd0);

    for (int n = 0; n < 400; n++) begin
      bit w = 1'($urandom);
      bit imm = 1'($urandom);
      run(w, imm, 1'($urandom), 5'($urandom), {$urandom, $urandom},
          {$urandom, $urandom}, 6'($urandom), w ? "R2" : "R1");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule